// File: doc/BRIEF.md
# Snooping Line Cache for Byte Requesters

Several byte-wide requesters share one wide memory controller whose natural word is 128 bits. This block gives each requester a private one-line buffer holding a single 16-byte memory word. A byte read that falls inside a port's buffered line is answered at once from that buffer. A read to any other line becomes a miss. Misses from all ports compete round-robin for a single memory read command port, and the returned word replaces the port's line.

Every write that any master sends to memory also appears on a shared write-observe bus, tagged with the writer's source number. The block snoops this bus. A write from a different source kills a matching line. The writer's own matching line is patched in place under the byte mask. A write that lands while a fetch of the same line is in flight still lets the fetched byte be delivered, but the line is not kept. In every case, a later read sees the written data.

Each port runs a three-state machine. IDLE accepts a request. On a hit it answers and stays in IDLE (IDLE→IDLE). On a miss it moves IDLE→REQ. REQ offers the line to the arbiter and moves REQ→WAIT when the command is accepted. WAIT holds until the port's fill returns, then delivers the byte and moves WAIT→IDLE.

Top module: `snoop_line_cache`

## Requirements
- R1: After reset, rd_valid and mem_valid are low and every port's line is invalid, so the first read of any line on any port causes a memory command.
- R2: A read whose line is held valid by that port, and which is not written on the observe bus in the same cycle, is answered with rd_valid at the clock edge that samples the request, and no memory command is issued for it.
- R3: A read to any other line moves the port to REQ. The port then presents mem_line = address[AW-1:4] and mem_id = port number. When the fill returns, the 128-bit word becomes the port's line and the requested byte is delivered with a one-cycle rd_valid.
- R4: The byte within the line is chosen by address[3:0]. Byte i of a line sits at bits [127-8i:120-8i], so byte 0 is bits [127:120]. Port p uses rd_addr[p*AW +: AW] and rd_data[8p +: 8].
- R5: A write on the observe bus whose wr_tag equals a port's valid line tag, and whose wr_src is not that port's number, invalidates that line. The port's next read of the line issues a new memory command.
- R6: A write from source p that hits port p's own valid line replaces each byte i for which wr_mask[i] is 1, where byte i is bits [127-8i:120-8i]. The line stays valid, and following reads of it hit with the new bytes.
- R7: A read request presented in the same cycle as a write to the same line is treated as a miss. mem_valid is never high in a cycle where the observe bus writes the line being commanded.
- R8: When a write to a port's pending line arrives while that port is in WAIT, or in the cycle its fill returns, the fill still answers the request but leaves the line invalid. The port's next read of that line fetches again.
- R9: Only one command is accepted per cycle, and only when mem_valid and mem_ready are both high. Ports in REQ are served round-robin: after a port's command is accepted, that port has the lowest priority.
- R10: A fill (mem_rvalid with mem_rid) is taken only by the port whose number equals mem_rid.
- R11: A requester holds rd_req and its address until rd_valid. rd_valid is raised only for a port that has a request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | NP | Per-port read request, held until answered |
| rd_addr | input | NP*AW | Per-port byte address, port p in slice p |
| rd_valid | output | NP | Per-port one-cycle answer strobe |
| rd_data | output | NP*8 | Per-port answered byte |
| wr_valid | input | 1 | A write is present on the observe bus |
| wr_src | input | IDW | Port number of the writer |
| wr_tag | input | AW-4 | Line address of the write |
| wr_data | input | 128 | Write data, byte 0 in the top bits |
| wr_mask | input | 16 | Byte enables, bit i for byte i |
| mem_valid | output | 1 | Read command offered |
| mem_line | output | AW-4 | Line address of the offered command |
| mem_id | output | IDW | Port that owns the offered command |
| mem_ready | input | 1 | Memory accepts the command this cycle |
| mem_rvalid | input | 1 | Fill word present |
| mem_rid | input | IDW | Port the fill belongs to |
| mem_rdata | input | 128 | Fill word |

## Verification
The bench builds the block with three ports and 16-bit addresses. The odd port count exercises the round-robin wrap where the pointer index exceeds the port count, and a 1 KiB behavioural memory holds every line the stimulus touches. The memory model applies ready stalls and fill latencies of one to ten cycles. This makes it possible to land a write while a fetch is still in flight, which is how the R8 window is reached. A command held in REQ by a stalled ready can also meet a write to its own line on the very edge it would have been accepted, which covers the R7 case.

// File: rtl/slc_pkg.sv
package slc_pkg;

    localparam int LINE_BYTES = 16;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int SEL_W      = $clog2(LINE_BYTES);

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_REQ,
        PS_WAIT
    } port_state_t;

    // byte i of a line lives at bits [127-8i -: 8]
    function automatic logic [7:0] line_byte(input logic [LINE_BITS-1:0] line,
                                             input logic [SEL_W-1:0] idx);
        return line[8*(LINE_BYTES-1-int'(idx)) +: 8];
    endfunction

    function automatic logic [LINE_BITS-1:0] line_merge(input logic [LINE_BITS-1:0] old_line,
                                                        input logic [LINE_BITS-1:0] new_line,
                                                        input logic [LINE_BYTES-1:0] mask);
        logic [LINE_BITS-1:0] res;
        res = old_line;
        for (int i = 0; i < LINE_BYTES; i++) begin
            if (mask[i]) begin
                res[8*(LINE_BYTES-1-i) +: 8] = new_line[8*(LINE_BYTES-1-i) +: 8];
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/slc_rr_arb.sv
module slc_rr_arb #(
    parameter int NP  = 4,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NP-1:0]  want,
    input  logic           advance,
    output logic [NP-1:0]  grant,
    output logic [IDW-1:0] gidx,
    output logic           any
);

    logic [IDW-1:0] ptr;

    always_comb begin
        grant = '0;
        gidx  = '0;
        any   = 1'b0;
        for (int k = 0; k < NP; k++) begin
            int idx;
            idx = (int'(ptr) + k) % NP;
            if (!any && want[idx]) begin
                any        = 1'b1;
                grant[idx] = 1'b1;
                gidx       = IDW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (int'(gidx) == NP-1) ? '0 : gidx + 1'b1;
        end
    end

    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_wanted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~want) == '0);

endmodule

// File: rtl/slc_port.sv
module slc_port
    import slc_pkg::*;
#(
    parameter int AW  = 32,
    parameter int IDW = 2,
    parameter int PID = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_req,
    input  logic [AW-1:0]         rd_addr,
    output logic                  rd_valid,
    output logic [7:0]            rd_data,
    input  logic                  wr_valid,
    input  logic [IDW-1:0]        wr_src,
    input  logic [AW-SEL_W-1:0]   wr_tag,
    input  logic [LINE_BITS-1:0]  wr_data,
    input  logic [LINE_BYTES-1:0] wr_mask,
    output logic                  cmd_want,
    output logic [AW-SEL_W-1:0]   cmd_tag,
    input  logic                  cmd_accept,
    input  logic                  fill_valid,
    input  logic [LINE_BITS-1:0]  fill_data
);

    localparam int TW = AW - SEL_W;

    port_state_t          state, state_nx;
    logic                 line_valid;
    logic [TW-1:0]        line_tag;
    logic [LINE_BITS-1:0] line_data;
    logic [TW-1:0]        pend_tag;
    logic [SEL_W-1:0]     pend_sel;
    logic                 poison;

    logic [TW-1:0]    req_tag;
    logic [SEL_W-1:0] req_sel;
    logic wr_on_req, wr_on_line, wr_on_pend, own_write, hit;

    assign req_tag = rd_addr[AW-1:SEL_W];
    assign req_sel = rd_addr[SEL_W-1:0];

    always_comb begin
        wr_on_req  = wr_valid && (wr_tag == req_tag);
        wr_on_line = wr_valid && line_valid && (wr_tag == line_tag);
        wr_on_pend = wr_valid && (wr_tag == pend_tag);
        own_write  = (wr_src == IDW'(PID));
        hit        = line_valid && (line_tag == req_tag) && !wr_on_req;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE: if (rd_req && !hit) state_nx = PS_REQ;
            PS_REQ:  if (cmd_accept)     state_nx = PS_WAIT;
            PS_WAIT: if (fill_valid)     state_nx = PS_IDLE;
            default: state_nx = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_valid <= 1'b0;
            line_tag   <= '0;
            line_data  <= '0;
            pend_tag   <= '0;
            pend_sel   <= '0;
            poison     <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (wr_on_line) begin
                if (own_write) line_data  <= line_merge(line_data, wr_data, wr_mask);
                else           line_valid <= 1'b0;
            end
            unique case (state)
                PS_IDLE: begin
                    if (rd_req) begin
                        if (hit) begin
                            rd_valid <= 1'b1;
                            rd_data  <= line_byte(line_data, req_sel);
                        end else begin
                            pend_tag <= req_tag;
                            pend_sel <= req_sel;
                            poison   <= 1'b0;
                        end
                    end
                end
                PS_REQ: begin
                end
                PS_WAIT: begin
                    if (wr_on_pend) poison <= 1'b1;
                    if (fill_valid) begin
                        line_tag   <= pend_tag;
                        line_data  <= fill_data;
                        line_valid <= !(poison || wr_on_pend);
                        rd_valid   <= 1'b1;
                        rd_data    <= line_byte(fill_data, pend_sel);
                        poison     <= 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign cmd_want = (state == PS_REQ);
    assign cmd_tag  = pend_tag;

    assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_IDLE) |-> rd_req);

    assert_no_cmd_beside_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> !wr_on_pend);

    assert_snoop_kills_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_on_line && !own_write && state != PS_WAIT) |=> !line_valid);

    assert_own_write_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_on_line && own_write && state != PS_WAIT) |=> line_valid);

    assert_poisoned_fill_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAIT && fill_valid && (poison || wr_on_pend)) |=> !line_valid);

    assert_fill_answers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAIT && fill_valid) |=> (rd_valid && line_tag == $past(pend_tag)));

endmodule

// File: rtl/snoop_line_cache.sv
module snoop_line_cache
    import slc_pkg::*;
#(
    parameter  int NP  = 4,
    parameter  int AW  = 32,
    localparam int IDW = (NP > 1) ? $clog2(NP) : 1,
    localparam int TW  = AW - SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NP-1:0]         rd_req,
    input  logic [NP*AW-1:0]      rd_addr,
    output logic [NP-1:0]         rd_valid,
    output logic [NP*8-1:0]       rd_data,
    input  logic                  wr_valid,
    input  logic [IDW-1:0]        wr_src,
    input  logic [TW-1:0]         wr_tag,
    input  logic [LINE_BITS-1:0]  wr_data,
    input  logic [LINE_BYTES-1:0] wr_mask,
    output logic                  mem_valid,
    output logic [TW-1:0]         mem_line,
    output logic [IDW-1:0]        mem_id,
    input  logic                  mem_ready,
    input  logic                  mem_rvalid,
    input  logic [IDW-1:0]        mem_rid,
    input  logic [LINE_BITS-1:0]  mem_rdata
);

    logic [NP-1:0]  want;
    logic [NP-1:0]  grant;
    logic [NP-1:0]  accept;
    logic [NP-1:0]  fill_hit;
    logic [TW-1:0]  port_tag [NP];
    logic [IDW-1:0] gidx;
    logic           any_want;
    logic           advance;

    slc_rr_arb #(.NP(NP), .IDW(IDW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .want    (want),
        .advance (advance),
        .grant   (grant),
        .gidx    (gidx),
        .any     (any_want)
    );

    // hold a command back while the same line is being written
    assign mem_line  = port_tag[gidx];
    assign mem_id    = gidx;
    assign mem_valid = any_want && !(wr_valid && (wr_tag == port_tag[gidx]));
    assign advance   = mem_valid && mem_ready;

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign accept[p]   = advance && grant[p];
        assign fill_hit[p] = mem_rvalid && (mem_rid == IDW'(p));

        slc_port #(.AW(AW), .IDW(IDW), .PID(p)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_req     (rd_req[p]),
            .rd_addr    (rd_addr[p*AW +: AW]),
            .rd_valid   (rd_valid[p]),
            .rd_data    (rd_data[p*8 +: 8]),
            .wr_valid   (wr_valid),
            .wr_src     (wr_src),
            .wr_tag     (wr_tag),
            .wr_data    (wr_data),
            .wr_mask    (wr_mask),
            .cmd_want   (want[p]),
            .cmd_tag    (port_tag[p]),
            .cmd_accept (accept[p]),
            .fill_valid (fill_hit[p]),
            .fill_data  (mem_rdata)
        );
    end

    assert_one_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(accept) <= 1);

    assert_fill_single_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_hit));

endmodule

// File: tb/test_snoop_line_cache.sv
module test_snoop_line_cache;

    localparam int NP = 3, AW = 16, IDW = 2, TW = 12, NBYTES = 1024;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic [NP-1:0] rd_req;
    logic [NP*AW-1:0] rd_addr;
    wire [NP-1:0] rd_valid;
    wire [NP*8-1:0] rd_data;
    logic wr_valid;
    logic [IDW-1:0] wr_src;
    logic [TW-1:0] wr_tag;
    logic [127:0] wr_data;
    logic [15:0] wr_mask;
    wire mem_valid;
    wire [TW-1:0] mem_line;
    wire [IDW-1:0] mem_id;
    logic mem_ready, mem_rvalid;
    logic [IDW-1:0] mem_rid;
    logic [127:0] mem_rdata;

    snoop_line_cache #(.NP(NP), .AW(AW)) i_snoop_line_cache (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_valid(wr_valid),
        .wr_src(wr_src), .wr_tag(wr_tag), .wr_data(wr_data), .wr_mask(wr_mask),
        .mem_valid(mem_valid), .mem_line(mem_line), .mem_id(mem_id),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rid(mem_rid),
        .mem_rdata(mem_rdata)
    );

    logic [7:0] ram [NBYTES];
    int errors = 0, checks = 0, cyc = 0;
    bit pend [NP]; int paddr [NP]; bit acc [NP]; logic [7:0] snap [NP];
    int ncmd [NP]; int age [NP];
    bit st_req [NP]; int st_addr [NP];
    bit w_st; int w_src, w_tag; logic [127:0] w_data; logic [15:0] w_mask;
    int lat_fix = 2; bit rdy_rand = 0; bit rdy_off = 0;
    int rq_id [$]; logic [127:0] rq_data [$]; int rq_due [$];
    int order [$];
    bit c_mv = 0; int c_ml = 0, c_mid = 0;

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [127:0] ram_line(int tag);
        logic [127:0] l;
        for (int i = 0; i < 16; i++) l[8*(15-i) +: 8] = ram[tag*16+i];
        return l;
    endfunction

    task automatic step();
        @(negedge clk);
        cyc++;
        // effects of the edge just passed
        if (wr_valid)
            for (int i = 0; i < 16; i++)
                if (wr_mask[i]) ram[int'(wr_tag)*16+i] = wr_data[8*(15-i) +: 8];
        if (c_mv && mem_ready) begin
            chk(!(wr_valid && int'(wr_tag) == c_ml), "R7 command beside write to its line", c_ml, -1);
            if (c_mid < NP) begin
                chk(pend[c_mid] && !acc[c_mid], "R3 command from a waiting port", c_mid, c_mid);
                chk(c_ml == paddr[c_mid]/16, "R3 command line", c_ml, paddr[c_mid]/16);
                acc[c_mid] = 1;
                snap[c_mid] = ram[c_ml*16 + paddr[c_mid]%16];
                ncmd[c_mid]++;
            end else chk(0, "R9 command id in range", c_mid, NP-1);
            order.push_back(c_mid);
            rq_id.push_back(c_mid);
            rq_data.push_back(ram_line(c_ml));
            rq_due.push_back(cyc + ((lat_fix > 0) ? lat_fix : 1 + int'($urandom % 5)));
        end
        for (int p = 0; p < NP; p++) if (pend[p]) age[p]++;
        for (int p = 0; p < NP; p++) begin
            if (rd_valid[p]) begin
                if (!pend[p]) chk(0, "R11 answer without request", p, -1);
                else begin
                    logic [7:0] e;
                    e = acc[p] ? snap[p] : ram[paddr[p]];
                    if (acc[p]) chk(rd_data[8*p +: 8] == e, "R3 R4 R10 fetched byte", int'(rd_data[8*p +: 8]), int'(e));
                    else begin
                        chk(rd_data[8*p +: 8] == e, "R2 R4 cached byte", int'(rd_data[8*p +: 8]), int'(e));
                        chk(age[p] == 1, "R2 hit answered in one cycle", age[p], 1);
                    end
                    pend[p] = 0;
                end
            end
        end
        // drive next cycle
        wr_valid = 0;
        if (w_st) begin
            wr_valid = 1; wr_src = IDW'(w_src); wr_tag = TW'(w_tag);
            wr_data = w_data; wr_mask = w_mask; w_st = 0;
        end
        mem_rvalid = 0;
        if (rq_id.size() > 0 && rq_due[0] <= cyc) begin
            mem_rvalid = 1; mem_rid = IDW'(rq_id.pop_front());
            mem_rdata = rq_data.pop_front(); void'(rq_due.pop_front());
        end
        mem_ready = rdy_off ? 1'b0 : (rdy_rand ? 1'($urandom % 2) : 1'b1);
        for (int p = 0; p < NP; p++) begin
            if (!pend[p] && st_req[p]) begin
                pend[p] = 1; acc[p] = 0; age[p] = 0; paddr[p] = st_addr[p]; st_req[p] = 0;
            end
            rd_req[p] = pend[p];
            rd_addr[p*AW +: AW] = paddr[p][AW-1:0];
        end
        #1;
        c_mv = mem_valid; c_ml = int'(mem_line); c_mid = int'(mem_id);
    endtask

    task automatic rd(int p, int a);
        st_req[p] = 1; st_addr[p] = a;
    endtask

    task automatic wr(int src, int tag, logic [15:0] mask);
        w_st = 1; w_src = src; w_tag = tag; w_mask = mask;
        w_data = {$urandom, $urandom, $urandom, $urandom};
    endtask

    function automatic bit busy();
        bit b = w_st || rq_id.size() > 0;
        for (int p = 0; p < NP; p++) b = b || pend[p] || st_req[p];
        return b;
    endfunction

    task automatic run_idle();
        int n = 0;
        while (busy()) begin
            step();
            n++;
            if (n > 3000) begin
                chk(0, "R11 request never answered", n, 3000);
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n0;
        for (int i = 0; i < NBYTES; i++) ram[i] = 8'((i*37 + 5) & 255);
        for (int p = 0; p < NP; p++) begin
            pend[p] = 0; acc[p] = 0; ncmd[p] = 0; st_req[p] = 0; paddr[p] = 0; age[p] = 0;
        end
        w_st = 0;
        rst_n = 0; rd_req = '0; rd_addr = '0; wr_valid = 0; wr_src = '0; wr_tag = '0;
        wr_data = '0; wr_mask = '0; mem_ready = 1; mem_rvalid = 0; mem_rid = '0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rd_valid == '0, "R1 rd_valid low after reset", int'(rd_valid), 0);
        chk(mem_valid == 1'b0, "R1 no command after reset", int'(mem_valid), 0);

        // R1 R3: first read misses; R2 R4: rest of the line hits
        rd(0, 'h20); run_idle();
        chk(ncmd[0] == 1, "R1 R3 first read fetches", ncmd[0], 1);
        for (int b = 1; b < 16; b++) begin rd(0, 'h20 + b); run_idle(); end
        chk(ncmd[0] == 1, "R2 hits issue no command", ncmd[0], 1);

        // R5: other-source write kills port 1's line
        rd(1, 'h20); run_idle();
        chk(ncmd[1] == 1, "R3 port 1 fetch", ncmd[1], 1);
        wr(0, 2, 16'h00F0); step(); run_idle();
        rd(1, 'h25); run_idle();
        chk(ncmd[1] == 2, "R5 refetch after foreign write", ncmd[1], 2);

        // R6: writer's own line merged and still valid
        n0 = ncmd[0];
        rd(0, 'h26); run_idle();
        rd(0, 'h23); run_idle();
        chk(ncmd[0] == n0, "R6 own line kept after write", ncmd[0], n0);

        // R7: read and write to same line in one cycle
        rd(2, 'h30); run_idle();
        n0 = ncmd[2];
        rd(2, 'h31); wr(1, 3, 16'hFFFF); step(); run_idle();
        chk(ncmd[2] == n0 + 1, "R7 same-cycle write forces miss", ncmd[2], n0 + 1);

        // R7: write lands on the edge a stalled command would be accepted
        rdy_off = 1; rd(2, 'h58); repeat (3) step();
        rdy_off = 0; wr(0, 5, 16'hFFFF); step(); run_idle();

        // R8: write while fetch in flight
        lat_fix = 10;
        n0 = ncmd[0];
        rd(0, 'h40);
        for (int k = 0; k < 50 && !acc[0]; k++) step();
        step();
        wr(2, 4, 16'hFFFF); step(); run_idle();
        rd(0, 'h41); run_idle();
        chk(ncmd[0] == n0 + 2, "R8 in-flight write leaves line invalid", ncmd[0], n0 + 2);

        // R9: all ports miss together
        lat_fix = 2; order.delete();
        rd(0, 'h50); rd(1, 'h60); rd(2, 'h70); run_idle();
        chk(order.size() == 3, "R9 three commands", order.size(), 3);
        if (order.size() == 3) begin
            chk(order[1] == (order[0] + 1) % NP, "R9 rotation second", order[1], (order[0] + 1) % NP);
            chk(order[2] == (order[0] + 2) % NP, "R9 rotation third", order[2], (order[0] + 2) % NP);
        end

        // mixed traffic with stalls and variable latency
        lat_fix = 0; rdy_rand = 1;
        for (int it = 0; it < 800; it++) begin
            for (int p = 0; p < NP; p++)
                if (!pend[p] && !st_req[p] && ($urandom % 3 == 0)) rd(p, int'($urandom % 128));
            if (!w_st && ($urandom % 4 == 0)) wr(int'($urandom % NP), int'($urandom % 8), 16'($urandom));
            step();
        end
        run_idle();
        rdy_rand = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule